// File: doc/BRIEF.md
# Delayed Branch Fetch Sequencer

This block holds the program counter of a short RISC pipeline and decides, every cycle, which word address goes out to the instruction memory. Register operations pass through two stages: fetch, then execute. Loads and stores add a third stage, a memory phase, after execute. The execute stage reports three things back to the sequencer: whether the instruction it holds is a branch, whether that branch is taken and where it goes, and whether the instruction needs the memory phase.

Branches are delayed. The sequencer never throws away a fetched word. The word fetched directly after a branch is the delay slot, and it always executes. Only the fetch after the slot goes to the branch target. When a load or store moves into its memory phase, fetch pauses for one cycle. A redirect that is still owed is kept through that pause. Each fetch is tagged so that downstream logic knows when it is carrying a delay-slot instruction.

Top module: `fetch_seq`

## Requirements
- R1: While reset is held, fetchAddr is 0, fetchValid is 1 and fetchDelaySlot is 0. The first cycle after reset fetches word address 0.
- R2: A valid fetch that is not a delay slot and has no owed redirect is followed by a fetch of fetchAddr + 1.
- R3: If the execute stage holds a valid branch that is not itself a delay slot, the next valid fetch is at the sequential address and has fetchDelaySlot = 1.
- R4: After a delay slot, the next valid fetch is at the branch target when exTaken was 1. It is at slot address + 1 when exTaken was 0.
- R5: A branch that sits in a delay slot is treated as a plain instruction. It causes no redirect, and the fetch after it is not flagged.
- R6: When memReq is 1 for a valid instruction in execute, the next cycle has fetchValid = 0 and fetchAddr keeps its value into the cycle after that.
- R7: If a branch executes during a memory-phase stall, its delay slot is the first fetch after the stall and is flagged. The target fetch follows the slot.
- R8: Execute-stage inputs are ignored in a cycle whose previous cycle issued no fetch. Such a cycle carries an execute bubble.
- R9: fetchDelaySlot is never 1 while fetchValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| exBranch | input | 1 | The instruction in execute is a branch |
| exTaken | input | 1 | Branch condition outcome, valid with exBranch |
| exTarget | input | ADDR_W | Branch target word address |
| memReq | input | 1 | The instruction in execute is a load or store |
| fetchAddr | output | ADDR_W | Instruction memory word address |
| fetchValid | output | 1 | A fetch is issued this cycle |
| fetchDelaySlot | output | 1 | The word fetched this cycle is a delay slot |

## Verification
The bench targets the paths where a redirect could land one fetch too early or too late. These are a taken branch, a not-taken branch, and a branch whose delay slot is itself a branch. A design that skipped the slot would jump one word early. A design that honoured nested branches would jump again to the second target. Stalls are combined with branches in two ways: a branch that executes during the stall, and a load placed in the delay slot. A design that dropped the owed redirect would fall through sequentially, and one that moved the PC during the stall would skip a word. Every bubble cycle drives a taken branch and a memory request as junk, so a design that listened to an empty execute stage would jump or stall for no reason.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  // Control to datapath PC update strobes
  typedef struct packed {
    logic advance;   // pc <= pc + step
    logic jumpEx;    // pc <= target from execute
    logic jumpSaved; // pc <= stored target
    logic capture;   // store execute target for later
  } fseqStrobes_t;
endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         exBranch,
  input  logic         exTaken,
  input  logic         memReq,
  output fseqStrobes_t strobes,
  output logic         fetchEn,
  output logic         slotFlag
);
  logic exValid;    // previous cycle issued a fetch
  logic memPhase;   // a load/store occupies memory phase now
  logic exInSlot;   // instruction in execute was a delay slot
  logic slotOwed;   // branch executed during stall, slot not yet fetched
  logic owedTaken;  // outcome of that branch

  logic branchNow, memNow, slotNow, takenEff;

  always_comb begin
    branchNow = exValid && exBranch && !exInSlot;
    memNow    = exValid && memReq;
    fetchEn   = !memPhase;
    slotNow   = branchNow || slotOwed;
    takenEff  = branchNow ? exTaken : owedTaken;
    slotFlag  = fetchEn && slotNow;

    strobes.jumpEx    = fetchEn && branchNow && exTaken;
    strobes.jumpSaved = fetchEn && slotOwed && owedTaken;
    strobes.advance   = fetchEn && !(slotNow && takenEff);
    strobes.capture   = branchNow && !fetchEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      exValid   <= 1'b0;
      memPhase  <= 1'b0;
      exInSlot  <= 1'b0;
      slotOwed  <= 1'b0;
      owedTaken <= 1'b0;
    end else begin
      exValid  <= fetchEn;
      memPhase <= memNow;
      exInSlot <= slotFlag;
      slotOwed <= slotNow && !fetchEn;
      if (branchNow) owedTaken <= exTaken;
    end
  end
endmodule

// File: rtl/fseq_dp.sv
module fseq_dp
  import fseq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STEP     = 1,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  fseqStrobes_t      strobes,
  input  logic [ADDR_W-1:0] exTarget,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] StepVal = ADDR_W'(STEP);

  logic [ADDR_W-1:0] savedTgt;
  logic [ADDR_W-1:0] pcNext;

  always_comb begin
    if (strobes.jumpEx)         pcNext = exTarget;
    else if (strobes.jumpSaved) pcNext = savedTgt;
    else if (strobes.advance)   pcNext = pc + StepVal;
    else                        pcNext = pc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc       <= RESET_PC;
      savedTgt <= '0;
    end else begin
      pc <= pcNext;
      if (strobes.capture) savedTgt <= exTarget;
    end
  end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              exBranch,
  input  logic              exTaken,
  input  logic [ADDR_W-1:0] exTarget,
  input  logic              memReq,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchValid,
  output logic              fetchDelaySlot
);
  import fseq_pkg::*;

  fseqStrobes_t strobes;

  fseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .exBranch (exBranch),
    .exTaken  (exTaken),
    .memReq   (memReq),
    .strobes  (strobes),
    .fetchEn  (fetchValid),
    .slotFlag (fetchDelaySlot)
  );

  fseq_dp #(.ADDR_W(ADDR_W), .STEP(1), .RESET_PC('0)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .exTarget (exTarget),
    .pc       (fetchAddr)
  );
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              exBranch,
  input logic              memReq,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              fetchValid,
  input logic              fetchDelaySlot
);
  logic prevValid, prevSlot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevSlot  <= 1'b0;
    end else begin
      prevValid <= fetchValid;
      prevSlot  <= fetchDelaySlot;
    end
  end

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !fetchDelaySlot) |=> fetchAddr == $past(fetchAddr) + ADDR_W'(1)); // R2

  AST_BRANCH_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && !prevSlot && exBranch && fetchValid) |-> fetchDelaySlot); // R3

  AST_NO_NESTED: assert property (@(posedge clk) disable iff (!rstN)
    fetchDelaySlot |=> !fetchDelaySlot); // R5

  AST_MEM_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && memReq) |=> !fetchValid); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |=> fetchAddr == $past(fetchAddr)); // R6

  AST_SLOT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    fetchDelaySlot |-> fetchValid); // R9
endmodule

bind fetch_seq fetch_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .exBranch       (exBranch),
  .memReq         (memReq),
  .fetchAddr      (fetchAddr),
  .fetchValid     (fetchValid),
  .fetchDelaySlot (fetchDelaySlot)
);

// File: tb/fetch_seq_bench.sv
module fetch_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        exBranch = 1'b0, exTaken = 1'b0, memReq = 1'b0;
  logic [31:0] exTarget = '0;
  logic [31:0] fetchAddr;
  logic        fetchValid, fetchDelaySlot;

  always #10 clk = ~clk; // 50 MHz

  fetch_seq u_fetch_seq (
    .clk(clk), .rstN(rstN), .exBranch(exBranch), .exTaken(exTaken),
    .exTarget(exTarget), .memReq(memReq), .fetchAddr(fetchAddr),
    .fetchValid(fetchValid), .fetchDelaySlot(fetchDelaySlot)
  );

  typedef struct {
    bit          v;
    logic [31:0] a;
    bit          s;
    string       tag;
  } expItem_t;

  expItem_t    sbQ[$];
  bit          pBr[64], pTk[64], pMem[64];
  logic [31:0] pTgt[64];
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  task automatic clearProg();
    for (int i = 0; i < 64; i++) begin
      pBr[i] = 0; pTk[i] = 0; pMem[i] = 0; pTgt[i] = '0;
    end
  endtask

  task automatic push(bit v, int a, bit s, string tag);
    expItem_t it;
    it.v = v; it.a = 32'(a); it.s = s; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic checkVal(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per cycle and compares it
  task automatic monitor();
    expItem_t it;
    it = sbQ.pop_front();
    checkVal(it.tag, "fetchValid", 32'(fetchValid), 32'(it.v));
    checkVal(it.tag, "fetchAddr", fetchAddr, it.a);
    checkVal(it.tag, "fetchDelaySlot", 32'(fetchDelaySlot), 32'(it.s));
  endtask

  task automatic runScenario();
    bit          lastV;
    logic [31:0] lastA;
    rstN = 1'b0;
    exBranch = 0; exTaken = 0; memReq = 0; exTarget = '0;
    repeat (3) @(negedge clk);
    #5;
    checkVal("R1", "reset fetchAddr", fetchAddr, 32'd0);
    checkVal("R1", "reset fetchValid", 32'(fetchValid), 32'd1);
    checkVal("R1", "reset fetchDelaySlot", 32'(fetchDelaySlot), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    lastV = 1'b0;
    lastA = '0;
    while (sbQ.size() > 0) begin
      if (lastV) begin
        exBranch = pBr[lastA[5:0]];
        exTaken  = pTk[lastA[5:0]];
        exTarget = pTgt[lastA[5:0]];
        memReq   = pMem[lastA[5:0]];
      end else begin
        // R8: junk on an execute bubble must be ignored
        exBranch = 1; exTaken = 1; exTarget = 32'd99; memReq = 1;
      end
      #5;
      monitor();
      lastV = fetchValid;
      lastA = fetchAddr;
      @(negedge clk);
    end
  endtask

  initial begin
    // R1 and R2: straight-line code
    clearProg();
    push(1, 0, 0, "R1"); push(1, 1, 0, "R2"); push(1, 2, 0, "R2");
    push(1, 3, 0, "R2"); push(1, 4, 0, "R2");
    runScenario();

    // R3 and R4: taken branch at 2 to 20
    clearProg();
    pBr[2] = 1; pTk[2] = 1; pTgt[2] = 20;
    push(1, 0, 0, "R2"); push(1, 1, 0, "R2"); push(1, 2, 0, "R2");
    push(1, 3, 1, "R3"); push(1, 20, 0, "R4"); push(1, 21, 0, "R4");
    runScenario();

    // R4: not-taken branch continues sequentially after slot
    clearProg();
    pBr[2] = 1; pTk[2] = 0; pTgt[2] = 20;
    push(1, 0, 0, "R2"); push(1, 1, 0, "R2"); push(1, 2, 0, "R2");
    push(1, 3, 1, "R3"); push(1, 4, 0, "R4"); push(1, 5, 0, "R4");
    runScenario();

    // R5: branch in delay slot is ignored
    clearProg();
    pBr[2] = 1; pTk[2] = 1; pTgt[2] = 10;
    pBr[3] = 1; pTk[3] = 1; pTgt[3] = 30;
    push(1, 0, 0, "R2"); push(1, 1, 0, "R2"); push(1, 2, 0, "R2");
    push(1, 3, 1, "R3"); push(1, 10, 0, "R5"); push(1, 11, 0, "R5");
    push(1, 12, 0, "R5");
    runScenario();

    // R5 contrast: branch at target (not a slot) still redirects
    clearProg();
    pBr[2] = 1; pTk[2] = 1; pTgt[2] = 20;
    pBr[20] = 1; pTk[20] = 1; pTgt[20] = 5;
    push(1, 0, 0, "R2"); push(1, 1, 0, "R2"); push(1, 2, 0, "R2");
    push(1, 3, 1, "R3"); push(1, 20, 0, "R4"); push(1, 21, 1, "R3");
    push(1, 5, 0, "R4"); push(1, 6, 0, "R2");
    runScenario();

    // R6 and R8: load at 1 stalls one cycle; bubble junk ignored
    clearProg();
    pMem[1] = 1;
    push(1, 0, 0, "R2"); push(1, 1, 0, "R2"); push(1, 2, 0, "R2");
    push(0, 3, 0, "R6"); push(1, 3, 0, "R6"); push(1, 4, 0, "R8");
    push(1, 5, 0, "R8");
    runScenario();

    // R7: branch at 2 executes during the stall caused by load at 1
    clearProg();
    pMem[1] = 1;
    pBr[2] = 1; pTk[2] = 1; pTgt[2] = 40;
    push(1, 0, 0, "R2"); push(1, 1, 0, "R2"); push(1, 2, 0, "R2");
    push(0, 3, 0, "R9"); push(1, 3, 1, "R7"); push(1, 40, 0, "R7");
    push(1, 41, 0, "R7");
    runScenario();

    // R6 with R4: load in the delay slot of a taken branch
    clearProg();
    pBr[2] = 1; pTk[2] = 1; pTgt[2] = 20;
    pMem[3] = 1;
    push(1, 0, 0, "R2"); push(1, 1, 0, "R2"); push(1, 2, 0, "R2");
    push(1, 3, 1, "R3"); push(1, 20, 0, "R4"); push(0, 21, 0, "R6");
    push(1, 21, 0, "R6"); push(1, 22, 0, "R8");
    runScenario();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule